// File: doc/BRIEF.md
# Dual-Bus Drive Protocol Interpreter

This block is the drive-side protocol logic for a parallel disk interface built from two byte-wide buses, each carrying its own odd parity bit. When the master raises its select line, the block listens on bus A for a leading control octet. While it listens, it drives its status byte back on bus B. It decodes the octet into one of four kinds. Command and response octets go to an 8-bit microcontroller port. Read and write octets go to a serializer/formatter port as a request.

For a read or write, the block leaves both buses undriven for one turnaround cycle. It then joins them into a single 16-bit path running in one direction: master to formatter for a write, formatter to master for a read. Data words are not stored. Each word crosses between the buses and the formatter combinationally, under a valid/ready handshake. A backpressure flag shows when the formatter holds the path up. Dropping select returns the block to idle from any phase.

Top module: `dbus_proto_if`

## Requirements
- R1: After reset, both output enables, all strobes, the request and the backpressure flag are low, and both microcontroller registers read 0.
- R2: The control octet's two most significant bits select its kind: 00 read, 01 write, 10 command, 11 response. This is decoded two cycles after select is sampled high, in the cycle after the octet is captured. For command or response, `uc_stb_o` pulses for one cycle, and `uc_irq_o` pulses with it only for command. For read or write, `fmt_req_o` pulses for one cycle, with `fmt_wr_o` high for write.
- R3: Each control octet is checked for odd parity, so that the ones in the byte plus its parity bit total an odd number. An octet that fails this check raises no strobe and no request and leaves the last-octet register unchanged. It also sets status bit 0.
- R4: Every byte the block drives on A or B carries odd parity.
- R5: During the control phase, bus A is an input and bus B drives the status byte.
- R6: Between the control phase and a data phase there is one cycle in which neither bus is driven. `a_oe_o` never rises without such a cycle immediately before it.
- R7: In a write transfer, {A,B} appears on `fmt_wdata_o` with A as the high byte. `fmt_wvld_o` equals `m_vld_i` only when both bytes pass parity. `s_rdy_o` follows `fmt_wrdy_i`. A word received with bad parity is not forwarded and sets status bit 1.
- R8: In a read transfer, both buses are driven: A carries `fmt_rdata_i[15:8]` and B carries `fmt_rdata_i[7:0]`. `s_vld_o` follows `fmt_rvld_i`, and `fmt_rrdy_o` follows `m_rdy_i`.
- R9: `bp_o` is high during a write transfer while `fmt_wrdy_i` is low, and during a read transfer while `fmt_rvld_i` is low. It is low otherwise.
- R10: When select is low, the block is in idle by the next cycle, with both buses undriven and status bit 2 (active) clear.
- R11: Register address 0 reads the last octet that passed parity. Address 1 reads the status byte: bit 0 is the control parity error, bit 1 the data parity error, bit 2 is set while the block is not idle, and the other bits are 0. A read strobe at address 1 clears bits 0 and 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Master select |
| ctl_vld_i | input | 1 | Control octet present on bus A |
| a_i | input | 8 | Bus A receive byte |
| a_par_i | input | 1 | Bus A receive parity |
| b_i | input | 8 | Bus B receive byte |
| b_par_i | input | 1 | Bus B receive parity |
| a_o | output | 8 | Bus A drive byte |
| a_par_o | output | 1 | Bus A drive parity |
| a_oe_o | output | 1 | Bus A output enable |
| b_o | output | 8 | Bus B drive byte |
| b_par_o | output | 1 | Bus B drive parity |
| b_oe_o | output | 1 | Bus B output enable |
| m_vld_i | input | 1 | Master word valid (write) |
| s_rdy_o | output | 1 | Drive ready for master word |
| s_vld_o | output | 1 | Drive word valid (read) |
| m_rdy_i | input | 1 | Master ready for drive word |
| fmt_req_o | output | 1 | Formatter request pulse |
| fmt_wr_o | output | 1 | Request is a write |
| fmt_wdata_o | output | 16 | Word to formatter |
| fmt_wvld_o | output | 1 | Word to formatter valid |
| fmt_wrdy_i | input | 1 | Formatter accepts word |
| fmt_rdata_i | input | 16 | Word from formatter |
| fmt_rvld_i | input | 1 | Word from formatter valid |
| fmt_rrdy_o | output | 1 | Master accepts formatter word |
| bp_o | output | 1 | Formatter backpressure |
| uc_stb_o | output | 1 | Command/response octet pulse |
| uc_irq_o | output | 1 | Command interrupt pulse |
| uc_addr_i | input | 1 | Register select |
| uc_rd_i | input | 1 | Register read strobe |
| uc_rdata_o | output | 8 | Register read data |

## Verification
A wrong control state shows at the bus enables within one cycle. Examples are B not driven while the block waits for an octet, A driven with no idle cycle before it, or an enable still high one cycle after select drops. A wrong decode of the octet kind shows in the cycle after capture, as a strobe or request on the wrong port. A wrong parity sense shows at once on the driven parity bits, or in the status byte read back after the transfer. The bench mixes random octets, parity faults and transfer lengths with directed cases, and checks each cycle against a model built from the requirements.

// File: rtl/dbus_proto_pkg.sv
package dbus_proto_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL_RX, ST_DECODE, ST_TURN, ST_XFER_IN, ST_XFER_OUT
  } st_e;

  typedef enum logic [1:0] {
    K_READ = 2'b00, K_WRITE = 2'b01, K_CMD = 2'b10, K_RESP = 2'b11
  } kind_e;
endpackage

// File: rtl/dbus_ctl_fsm.sv
module dbus_ctl_fsm
  import dbus_proto_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              ctl_vld_i,
  input  logic [BYTE_W-1:0] octet_i,
  input  logic              octet_ok_i,
  output st_e               state_o,
  output logic              cap_o,
  output logic              oct_ok_o,
  output kind_e             kind_o
);
  st_e               st_q, st_d;
  logic [BYTE_W-1:0] oct_q;
  logic              ok_q;

  assign cap_o    = (st_q == ST_CTRL_RX) && sel_i && ctl_vld_i;
  assign kind_o   = kind_e'(oct_q[BYTE_W-1 -: 2]);
  assign oct_ok_o = ok_q;
  assign state_o  = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (sel_i) st_d = ST_CTRL_RX;
      ST_CTRL_RX:  if (ctl_vld_i) st_d = ST_DECODE;
      ST_DECODE:   st_d = (ok_q && !kind_o[1]) ? ST_TURN : ST_CTRL_RX;
      ST_TURN:     st_d = (kind_o == K_READ) ? ST_XFER_OUT : ST_XFER_IN;
      ST_XFER_IN,
      ST_XFER_OUT: st_d = st_q;
      default:     st_d = ST_IDLE;
    endcase
    if (!sel_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      oct_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_o) begin
        oct_q <= octet_i;
        ok_q  <= octet_ok_i;
      end
    end
  end

  // R10: a low select forces idle on the next edge
  p_sel_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && st_q != ST_IDLE) |=> (st_q == ST_IDLE));
  // R6: data phases are only entered through the turnaround state
  p_turn_before_xfer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_XFER_IN || st_q == ST_XFER_OUT) && $past(st_q) != st_q)
      |-> ($past(st_q) == ST_TURN));
endmodule

// File: rtl/dbus_uc_regs.sv
module dbus_uc_regs #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              ok_i,
  input  logic [BYTE_W-1:0] octet_i,
  input  logic              dat_err_i,
  input  logic              active_i,
  input  logic              addr_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] last_q;
  logic              ctl_err_q, dat_err_q;
  logic              clr;

  assign clr      = rd_i && addr_i;
  assign status_o = {{(BYTE_W-3){1'b0}}, active_i, dat_err_q, ctl_err_q};
  assign rdata_o  = addr_i ? status_o : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q    <= '0;
      ctl_err_q <= 1'b0;
      dat_err_q <= 1'b0;
    end else begin
      if (cap_i && ok_i) last_q <= octet_i;
      // a new error wins over a simultaneous clear
      ctl_err_q <= (cap_i && !ok_i) || (ctl_err_q && !clr);
      dat_err_q <= dat_err_i || (dat_err_q && !clr);
    end
  end

  // R3: a rejected octet leaves the last-octet register untouched
  p_keep_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !ok_i) |=> $stable(last_q));
  // R11: an error cannot vanish without a clearing read
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_err_q && !clr) |=> ctl_err_q);
endmodule

// File: rtl/dbus_proto_if.sv
module dbus_proto_if
  import dbus_proto_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                ctl_vld_i,
  input  logic [BYTE_W-1:0]   a_i,
  input  logic                a_par_i,
  input  logic [BYTE_W-1:0]   b_i,
  input  logic                b_par_i,
  output logic [BYTE_W-1:0]   a_o,
  output logic                a_par_o,
  output logic                a_oe_o,
  output logic [BYTE_W-1:0]   b_o,
  output logic                b_par_o,
  output logic                b_oe_o,
  input  logic                m_vld_i,
  output logic                s_rdy_o,
  output logic                s_vld_o,
  input  logic                m_rdy_i,
  output logic                fmt_req_o,
  output logic                fmt_wr_o,
  output logic [2*BYTE_W-1:0] fmt_wdata_o,
  output logic                fmt_wvld_o,
  input  logic                fmt_wrdy_i,
  input  logic [2*BYTE_W-1:0] fmt_rdata_i,
  input  logic                fmt_rvld_i,
  output logic                fmt_rrdy_o,
  output logic                bp_o,
  output logic                uc_stb_o,
  output logic                uc_irq_o,
  input  logic                uc_addr_i,
  input  logic                uc_rd_i,
  output logic [BYTE_W-1:0]   uc_rdata_o
);
  localparam int NLANE  = 2;
  localparam int WORD_W = NLANE * BYTE_W;

  st_e   st;
  kind_e kind;
  logic  cap, oct_ok, ctl_ph, x_in, x_out, dec_ok, word_ok, dat_err;
  logic [BYTE_W-1:0] status;

  // lane 0 = bus A (high byte), lane 1 = bus B (low byte)
  logic [NLANE-1:0][BYTE_W-1:0] rx_byte, tx_byte;
  logic [NLANE-1:0]             rx_par, rx_ok, tx_par;

  assign rx_byte = {b_i, a_i};
  assign rx_par  = {b_par_i, a_par_i};

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign rx_ok[l]  = ^{rx_byte[l], rx_par[l]};
    assign tx_par[l] = ~^tx_byte[l];
  end

  dbus_ctl_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk_i, .rst_ni, .sel_i, .ctl_vld_i,
    .octet_i(a_i), .octet_ok_i(rx_ok[0]),
    .state_o(st), .cap_o(cap), .oct_ok_o(oct_ok), .kind_o(kind)
  );

  assign ctl_ph = (st == ST_CTRL_RX) || (st == ST_DECODE);
  assign x_in   = (st == ST_XFER_IN);
  assign x_out  = (st == ST_XFER_OUT);
  assign dec_ok = (st == ST_DECODE) && oct_ok;

  assign uc_stb_o  = dec_ok && kind[1];
  assign uc_irq_o  = dec_ok && (kind == K_CMD);
  assign fmt_req_o = dec_ok && !kind[1];
  assign fmt_wr_o  = fmt_req_o && (kind == K_WRITE);

  assign tx_byte[0] = x_out ? fmt_rdata_i[WORD_W-1 -: BYTE_W] : '0;
  assign tx_byte[1] = x_out ? fmt_rdata_i[BYTE_W-1:0] : status;
  assign a_o     = tx_byte[0];
  assign b_o     = tx_byte[1];
  assign a_par_o = tx_par[0];
  assign b_par_o = tx_par[1];
  assign a_oe_o  = x_out;
  assign b_oe_o  = x_out || ctl_ph;

  assign word_ok     = &rx_ok;
  assign fmt_wdata_o = {a_i, b_i};
  assign fmt_wvld_o  = x_in && m_vld_i && word_ok;
  assign s_rdy_o     = x_in && fmt_wrdy_i;
  assign dat_err     = x_in && m_vld_i && !word_ok;

  assign s_vld_o    = x_out && fmt_rvld_i;
  assign fmt_rrdy_o = x_out && m_rdy_i;

  assign bp_o = (x_in && !fmt_wrdy_i) || (x_out && !fmt_rvld_i);

  dbus_uc_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk_i, .rst_ni, .cap_i(cap), .ok_i(rx_ok[0]), .octet_i(a_i),
    .dat_err_i(dat_err), .active_i(st != ST_IDLE),
    .addr_i(uc_addr_i), .rd_i(uc_rd_i),
    .status_o(status), .rdata_o(uc_rdata_o)
  );

  // R6: bus A is never enabled straight out of a driven cycle
  p_a_turn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(a_oe_o) |-> $past(!a_oe_o && !b_oe_o));
  // R4: driven bytes carry odd parity
  p_par_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_o |-> (^{a_o, a_par_o}));
  p_par_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_oe_o |-> (^{b_o, b_par_o}));
  // R2: handoff pulses last one cycle and go to one port only
  p_stb_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uc_stb_o |=> !uc_stb_o);
  p_one_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({uc_stb_o, fmt_req_o}));
  // R8: A is only driven together with B
  p_a_with_b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_o |-> b_oe_o);
  // R7: no forwarded word outside a write phase
  p_wvld_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_wvld_o |-> (!a_oe_o && !b_oe_o));
endmodule

// File: tb/dbus_proto_if_bench.sv
module dbus_proto_if_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 0, ctl_vld = 0, a_par = 0, b_par = 0;
  logic [7:0]  a_in = 0, b_in = 0;
  logic [7:0]  a_o, b_o, uc_rdata;
  logic        a_par_o, a_oe, b_par_o, b_oe;
  logic        m_vld = 0, s_rdy, s_vld, m_rdy = 0;
  logic        fmt_req, fmt_wr, fmt_wvld, fmt_wrdy = 0, fmt_rvld = 0, fmt_rrdy;
  logic [15:0] fmt_wdata, fmt_rdata = 0;
  logic        bp, uc_stb, uc_irq, uc_addr = 0, uc_rd = 0;

  int checks = 0, errors = 0;
  logic [7:0] m_last = 0;
  logic m_cerr = 0, m_derr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbus_proto_if u_dbus_proto_if (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .ctl_vld_i(ctl_vld),
    .a_i(a_in), .a_par_i(a_par), .b_i(b_in), .b_par_i(b_par),
    .a_o, .a_par_o, .a_oe_o(a_oe), .b_o, .b_par_o, .b_oe_o(b_oe),
    .m_vld_i(m_vld), .s_rdy_o(s_rdy), .s_vld_o(s_vld), .m_rdy_i(m_rdy),
    .fmt_req_o(fmt_req), .fmt_wr_o(fmt_wr), .fmt_wdata_o(fmt_wdata),
    .fmt_wvld_o(fmt_wvld), .fmt_wrdy_i(fmt_wrdy), .fmt_rdata_i(fmt_rdata),
    .fmt_rvld_i(fmt_rvld), .fmt_rrdy_o(fmt_rrdy), .bp_o(bp),
    .uc_stb_o(uc_stb), .uc_irq_o(uc_irq), .uc_addr_i(uc_addr),
    .uc_rd_i(uc_rd), .uc_rdata_o(uc_rdata)
  );

  function automatic logic oddp(input logic [7:0] d);
    return ~^d;
  endfunction

  function automatic logic [7:0] exp_status(input logic active);
    return {5'b0, active, m_derr, m_cerr};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic addr, input logic [7:0] exp, input string req);
    uc_addr = addr;
    #1 chk(uc_rdata == exp, req, uc_rdata, exp);
  endtask

  task automatic clear_errs();
    @(negedge clk); uc_addr = 1; uc_rd = 1;
    @(negedge clk); uc_rd = 0;
    m_cerr = 0; m_derr = 0;
    read_reg(1'b1, exp_status(1'b0), "R11 clear");
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(!a_oe && !b_oe, "R10 enables", {a_oe, b_oe}, 0);
    read_reg(1'b1, exp_status(1'b0), "R10 status");
    read_reg(1'b0, m_last, "R11 last octet");
  endtask

  task automatic transact(input logic [1:0] kind, input bit bad, input int nwords);
    logic [7:0] oct;
    oct = {kind, 6'($urandom)};
    @(negedge clk); sel = 1;
    @(negedge clk);
    chk(b_oe && !a_oe, "R5 control phase", {a_oe, b_oe}, 1);
    chk(b_o == exp_status(1'b1), "R5 status on B", b_o, exp_status(1'b1));
    chk(b_par_o == oddp(b_o), "R4 parity B ctl", b_par_o, oddp(b_o));
    a_in = oct; a_par = oddp(oct) ^ bad; ctl_vld = 1;
    @(negedge clk);
    ctl_vld = 0;
    if (bad) begin
      chk({uc_stb, uc_irq, fmt_req} == 0, "R3 rejected", {uc_stb, uc_irq, fmt_req}, 0);
      m_cerr = 1;
    end else begin
      m_last = oct;
      chk(uc_stb == kind[1], "R2 uc strobe", uc_stb, kind[1]);
      chk(uc_irq == (kind == 2'b10), "R2 irq", uc_irq, kind == 2'b10);
      chk(fmt_req == !kind[1], "R2 fmt req", fmt_req, !kind[1]);
      if (!kind[1]) chk(fmt_wr == kind[0], "R2 fmt wr", fmt_wr, kind[0]);
    end
    if (bad || kind[1]) begin
      @(negedge clk);
      chk(b_oe && !a_oe && !uc_stb && !fmt_req, "R5 back to ctl", {a_oe, b_oe, uc_stb}, 1);
    end else begin
      @(negedge clk);
      chk(!a_oe && !b_oe, "R6 turnaround", {a_oe, b_oe}, 0);
      for (int w = 0; w < nwords; w++) begin
        logic [15:0] d;
        logic rdy, vld, wb;
        @(negedge clk);
        d = 16'($urandom); rdy = 1'($urandom); vld = 1'($urandom);
        wb = ($urandom % 6) == 0;
        if (kind[0]) begin
          a_in = d[15:8]; b_in = d[7:0];
          a_par = oddp(d[15:8]) ^ wb; b_par = oddp(d[7:0]);
          m_vld = vld; fmt_wrdy = rdy;
          #1;
          chk(!a_oe && !b_oe, "R7 buses input", {a_oe, b_oe}, 0);
          chk(fmt_wdata == d, "R7 wdata", fmt_wdata, d);
          chk(fmt_wvld == (vld && !wb), "R7 wvld", fmt_wvld, vld && !wb);
          chk(s_rdy == rdy, "R7 s_rdy", s_rdy, rdy);
          chk(bp == !rdy, "R9 bp write", bp, !rdy);
          if (vld && wb) m_derr = 1;
        end else begin
          fmt_rdata = d; fmt_rvld = vld; m_rdy = rdy;
          #1;
          chk(a_oe && b_oe, "R8 buses driven", {a_oe, b_oe}, 3);
          chk({a_o, b_o} == d, "R8 rdata", {a_o, b_o}, d);
          chk(a_par_o == oddp(d[15:8]) && b_par_o == oddp(d[7:0]),
              "R4 parity data", {a_par_o, b_par_o}, {oddp(d[15:8]), oddp(d[7:0])});
          chk(s_vld == vld && fmt_rrdy == rdy, "R8 handshake", {s_vld, fmt_rrdy}, {vld, rdy});
          chk(bp == !vld, "R9 bp read", bp, !vld);
        end
      end
      @(negedge clk);
      m_vld = 0; fmt_rvld = 0; m_rdy = 0;
      a_par = oddp(a_in); b_par = oddp(b_in);
    end
    sel = 0;
    idle_check();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1985));
    repeat (3) @(negedge clk);
    chk(!a_oe && !b_oe && !uc_stb && !fmt_req && !bp, "R1 reset outputs",
        {a_oe, b_oe, uc_stb, fmt_req, bp}, 0);
    read_reg(1'b0, 8'h00, "R1 last octet");
    read_reg(1'b1, 8'h00, "R1 status");
    rst_n = 1;
    // directed: each kind, a bad octet, clear
    transact(2'b10, 0, 0);
    transact(2'b11, 0, 0);
    transact(2'b00, 0, 4);
    transact(2'b01, 0, 4);
    transact(2'b10, 1, 0);
    read_reg(1'b1, exp_status(1'b0), "R3 error bit");
    clear_errs();
    // directed: drop select mid-write
    @(negedge clk); sel = 1;
    @(negedge clk); a_in = 8'h40; a_par = oddp(8'h40); ctl_vld = 1; m_last = 8'h40;
    @(negedge clk); ctl_vld = 0;
    @(negedge clk); @(negedge clk);
    sel = 0;
    idle_check();
    // random
    for (int i = 0; i < 150; i++) begin
      transact(2'($urandom), ($urandom % 5) == 0, 1 + ($urandom % 6));
      if ((i % 7) == 0) clear_errs();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule